// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical byte address by adding it to a 16-bit segment base that is moved up by one hex digit. It holds four segment base registers: code, data, extra and stack. Each base names a 64 KB window that starts on a 16-byte boundary. For example, a base of 34BAh covers 34BA0h up to 44B9Fh.

Each request carries an access kind. The kind selects a default segment:
- An instruction fetch uses the code segment.
- A stack access (offset built from the stack or frame pointer) uses the stack segment.
- A plain data access (offset from a base or index register) uses the data segment.
- A string destination uses the extra segment.

An optional override names another segment for stack and data accesses. Fetches and string destinations always keep their fixed segment. The result is registered and comes with a valid strobe and the index of the segment that was used.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is 0, out_addr is 0, out_seg is 0 and all four segment registers read as 0000h.
- R2: A segment write (wr_en, with wr_sel encoded as code=0, data=1, extra=2, stack=3) updates the register at the clock edge. A request sampled at that same edge still uses the old value.
- R3: out_addr equals segment*16 + offset, truncated to 20 bits, so a sum beyond FFFFFh wraps around to the bottom of the space.
- R4: req_kind=0 (instruction fetch) always uses the code segment, whatever the override inputs hold.
- R5: req_kind=1 (stack access) uses the stack segment when ovr_valid is 0.
- R6: req_kind=2 (data access) uses the data segment when ovr_valid is 0.
- R7: req_kind=3 (string destination) always uses the extra segment, whatever the override inputs hold.
- R8: For req_kind 1 or 2 with ovr_valid=1, the segment named by ovr_sel (same encoding as wr_sel) replaces the default.
- R9: A request sampled at a clock edge gives out_valid=1 after that edge. A cycle with no request gives out_valid=0, and out_addr and out_seg keep their values.
- R10: out_seg reports the index of the segment used, encoded as code=0, data=1, extra=2, stack=3.
- R11: A write to one segment register leaves the other three unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Segment register write enable |
| wr_sel | input | 2 | Segment register to write |
| wr_data | input | 16 | New segment base |
| req_valid | input | 1 | Address request strobe |
| req_kind | input | 2 | Access kind: fetch, stack, data, string destination |
| req_offset | input | 16 | Offset within the segment |
| ovr_valid | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment index |
| out_valid | output | 1 | Registered result strobe |
| out_addr | output | 20 | Physical address |
| out_seg | output | 2 | Segment index used |

## Verification
There is one register between a request and its result. A request that is present at a rising edge shows its address, segment index and strobe during the cycle that follows. A segment write becomes visible only to requests sampled at a later edge.

The bench drives its inputs on falling edges and reads the outputs on the next falling edge, which is half a period after the edge that captured them. The write-then-request check relies on this timing: it issues both in the same cycle and expects the old base, then issues a second request and expects the new one.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
    localparam int SEG_W   = 16;
    localparam int OFF_W   = 16;
    localparam int SHIFT   = 4;
    localparam int NUM_SEG = 4;
    localparam int IDX_W   = $clog2(NUM_SEG);
    localparam int ADDR_W  = SEG_W + SHIFT;

    typedef enum logic [1:0] {
        ACC_FETCH  = 2'd0,
        ACC_STACK  = 2'd1,
        ACC_DATA   = 2'd2,
        ACC_STRDST = 2'd3
    } acc_kind_e;

    typedef enum logic [IDX_W-1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_EXTRA = 2'd2,
        SEG_STACK = 2'd3
    } seg_idx_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_addr_pkg::*;
#(
    parameter int W   = SEG_W,
    parameter int N   = NUM_SEG,
    localparam int IW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_sel,
    input  logic [W-1:0]        wr_data,
    output logic [N-1:0][W-1:0] seg_o
);
    for (genvar g = 0; g < N; g++) begin : g_seg
        logic [W-1:0] base_d, base_q;

        always_comb begin
            base_d = base_q;
            if (wr_en && (wr_sel == IW'(g))) begin
                base_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) base_q <= '0;
            else        base_q <= base_d;
        end

        assign seg_o[g] = base_q;
    end
endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_addr_pkg::*;
(
    input  acc_kind_e  kind_i,
    input  logic       ovr_valid_i,
    input  seg_idx_e   ovr_sel_i,
    output seg_idx_e   idx_o
);
    always_comb begin
        unique case (kind_i)
            ACC_FETCH:  idx_o = SEG_CODE;
            ACC_STRDST: idx_o = SEG_EXTRA;
            ACC_STACK:  idx_o = ovr_valid_i ? ovr_sel_i : SEG_STACK;
            ACC_DATA:   idx_o = ovr_valid_i ? ovr_sel_i : SEG_DATA;
            default:    idx_o = SEG_CODE;
        endcase
    end
endmodule

// File: rtl/seg_adder.sv
module seg_adder
    import seg_addr_pkg::*;
#(
    parameter int W    = SEG_W,
    parameter int N    = NUM_SEG,
    parameter int OW   = OFF_W,
    parameter int SH   = SHIFT,
    localparam int IW  = $clog2(N),
    localparam int AW  = W + SH
) (
    input  logic [N-1:0][W-1:0] seg_i,
    input  logic [IW-1:0]       idx_i,
    input  logic [OW-1:0]       off_i,
    output logic [AW-1:0]       addr_o
);
    logic [W-1:0]  base;
    logic [AW-1:0] base_sh;
    logic [AW-1:0] off_ext;

    always_comb begin
        base    = seg_i[idx_i];
        base_sh = {base, {SH{1'b0}}};
        off_ext = AW'(off_i);
        addr_o  = base_sh + off_ext;
    end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_sel,
    input  logic [SEG_W-1:0]  wr_data,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic              ovr_valid,
    input  logic [IDX_W-1:0]  ovr_sel,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [IDX_W-1:0]  out_seg
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  seg;
    } out_t;

    logic [NUM_SEG-1:0][SEG_W-1:0] seg_all;
    seg_idx_e                      sel_idx;
    logic [ADDR_W-1:0]             sum;
    out_t                          res_d, res_q;

    seg_regfile #(.W(SEG_W), .N(NUM_SEG)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .seg_o   (seg_all)
    );

    seg_select u_sel (
        .kind_i      (acc_kind_e'(req_kind)),
        .ovr_valid_i (ovr_valid),
        .ovr_sel_i   (seg_idx_e'(ovr_sel)),
        .idx_o       (sel_idx)
    );

    seg_adder #(.W(SEG_W), .N(NUM_SEG), .OW(OFF_W), .SH(SHIFT)) u_add (
        .seg_i  (seg_all),
        .idx_i  (sel_idx),
        .off_i  (req_offset),
        .addr_o (sum)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = req_valid;
        if (req_valid) begin
            res_d.addr = sum;
            res_d.seg  = sel_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.vld;
    assign out_addr  = res_q.addr;
    assign out_seg   = res_q.seg;
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk
    import seg_addr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic              ovr_valid,
    input logic [IDX_W-1:0]  ovr_sel,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic [IDX_W-1:0]  out_seg
);
    // R1: no strobe while held in reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R9: a request yields a strobe one cycle later
    assert_req_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R9: idle cycles hold the result
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && $stable(out_addr) && $stable(out_seg)));

    // R4: fetch ignores any override
    assert_fetch_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd0) |=> out_seg == 2'd0);

    // R7: string destination ignores any override
    assert_strdst_extra_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3) |=> out_seg == 2'd2);

    // R8: override honoured on stack and data kinds
    assert_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ovr_valid && (req_kind == 2'd1 || req_kind == 2'd2))
        |=> out_seg == $past(ovr_sel));

    // R5: stack default without override
    assert_stack_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ovr_valid && req_kind == 2'd1) |=> out_seg == 2'd3);

    // R6: data default without override
    assert_data_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ovr_valid && req_kind == 2'd2) |=> out_seg == 2'd1);
endmodule

bind seg_addr_gen seg_addr_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .ovr_valid (ovr_valid),
    .ovr_sel   (ovr_sel),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .out_seg   (out_seg)
);

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [15:0] req_offset = '0;
    logic        ovr_valid = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic        out_valid;
    logic [19:0] out_addr;
    logic [1:0]  out_seg;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .req_valid(req_valid), .req_kind(req_kind), .req_offset(req_offset),
        .ovr_valid(ovr_valid), .ovr_sel(ovr_sel),
        .out_valid(out_valid), .out_addr(out_addr), .out_seg(out_seg)
    );

    // {kind[22:21], ovr_v[20], ovr_sel[19:18], exp_seg[17:16], offset[15:0]}
    localparam logic [22:0] VEC [8] = '{
        {2'd0, 1'b0, 2'd0, 2'd0, 16'h0100},  // R4 fetch
        {2'd0, 1'b1, 2'd3, 2'd0, 16'hFFFF},  // R4 override ignored
        {2'd1, 1'b0, 2'd0, 2'd3, 16'hFFFE},  // R5
        {2'd1, 1'b1, 2'd1, 2'd1, 16'h0040},  // R8 on stack
        {2'd2, 1'b0, 2'd2, 2'd1, 16'h0010},  // R6
        {2'd2, 1'b1, 2'd2, 2'd2, 16'h8000},  // R8 on data
        {2'd3, 1'b1, 2'd0, 2'd2, 16'h0002},  // R7 override ignored
        {2'd2, 1'b1, 2'd0, 2'd0, 16'h1234}   // R8 code via override
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic seg_write(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
        model[sel] = val;
    endtask

    // drive a request, return after outputs for it are visible
    task automatic request(input logic [1:0] k, input logic [15:0] off,
                           input logic ov, input logic [1:0] os);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_offset = off; ovr_valid = ov; ovr_sel = os;
        @(negedge clk);
        req_valid = 1'b0; ovr_valid = 1'b0;
    endtask

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        logic [20:0] full;
        full = {1'b0, s, 4'h0} + {5'h0, o};
        return full[19:0];
    endfunction

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 valid in reset", 32'(out_valid), 0);
        chk("R1 addr in reset", 32'(out_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", 32'(out_valid), 0);
        chk("R1 seg after reset", 32'(out_seg), 0);
        // R1: registers zero, so address equals offset
        request(2'd1, 16'h1234, 1'b0, 2'd0);
        chk("R1 zero base", 32'(out_addr), 32'h01234);

        seg_write(2'd0, 16'h34BA);
        seg_write(2'd1, 16'h44EB);
        seg_write(2'd2, 16'h54EB);
        seg_write(2'd3, 16'h695E);

        // vector walk: R3..R8, R10, R11
        for (int v = 0; v < 8; v++) begin
            request(VEC[v][22:21], VEC[v][15:0], VEC[v][20], VEC[v][19:18]);
            chk("R9 strobe", 32'(out_valid), 1);
            chk("R10 seg index", 32'(out_seg), 32'(VEC[v][17:16]));
            chk("R3 address", 32'(out_addr), 32'(phys(model[VEC[v][17:16]], VEC[v][15:0])));
        end

        // R9: idle cycle holds address, strobe low
        @(negedge clk);
        chk("R9 idle valid", 32'(out_valid), 0);
        chk("R9 idle addr hold", 32'(out_addr), 32'(phys(16'h34BA, 16'h1234)));
        chk("R9 idle seg hold", 32'(out_seg), 0);

        // R3 wrap past FFFFFh, R11 others intact
        seg_write(2'd1, 16'hFFFF);
        request(2'd2, 16'h0020, 1'b0, 2'd0);
        chk("R3 wrap", 32'(out_addr), 32'h00010);
        request(2'd0, 16'h0000, 1'b0, 2'd0);
        chk("R11 code intact", 32'(out_addr), 32'h34BA0);
        request(2'd1, 16'h0000, 1'b0, 2'd0);
        chk("R11 stack intact", 32'(out_addr), 32'h695E0);
        request(2'd3, 16'h0000, 1'b0, 2'd0);
        chk("R11 extra intact", 32'(out_addr), 32'h54EB0);

        // R2: write and request at the same edge use old base
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'h1000;
        req_valid = 1'b1; req_kind = 2'd0; req_offset = 16'h0005;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        chk("R2 old base same edge", 32'(out_addr), 32'h34BA5);
        request(2'd0, 16'h0005, 1'b0, 2'd0);
        chk("R2 new base next", 32'(out_addr), 32'h10005);

        // R1: reset mid-run clears result and registers
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 rereset addr", 32'(out_addr), 0);
        rst_n = 1'b1;
        request(2'd3, 16'h00AB, 1'b0, 2'd0);
        chk("R1 rereset base", 32'(out_addr), 32'h000AB);

        finish_run();
    end
endmodule